// File: doc/BRIEF.md
# Current-Source Inverter Gate Sequencer with State-Limit Mode Selection

This block produces the six gate commands for a single-stage boost inverter built around a current-source bridge (four switches) and an active buffer leg (two switches). A free-running carrier counter divides time into switching periods of a fixed number of clock cycles. Each period opens with an energy-feeding interval whose length is set by a duty word. In that interval the bridge steers the inductor current into the output, in the direction given by the output polarity.

The rest of each period is not a fixed freewheel state. One of three drive patterns is chosen from two state limits: the inductor is magnetized from the source, or the buffer capacitor is discharged into the inductor, or the inductor is allowed to charge the buffer through its diodes with every switch open. An inductor current above its limit takes priority over the buffer voltage limit. The duty word and the three condition flags are captured once, at the start of each period, and are held for the whole period.

A regulator elsewhere supplies the duty word. Comparators elsewhere supply the flags. The outputs go to the gate drivers.

Top module: `cspwm_sequencer`

## Requirements
- R1: While enabled, the carrier counts 0, 1, ..., PERIOD-1 and then wraps to 0, so every switching period lasts exactly PERIOD clock cycles.
- R2: The feeding interval covers the first D cycles of each period, where D is the duty captured for that period. The remaining PERIOD-D cycles are the non-feeding interval.
- R3: In the feeding interval with the polarity flag at 1 (positive output), exactly S1 and S4 are on. Gate bus bit 0 is S1, bit 1 is S2, bit 2 is S3, bit 3 is S4, bit 4 is S5 and bit 5 is S6, which gives 6'b001001.
- R4: In the feeding interval with the polarity flag at 0 (negative output), exactly S2 and S3 are on (6'b000110).
- R5: In the non-feeding interval, with the current-over flag at 0 and the voltage-over flag at 0, the magnetizing pattern is driven: exactly S1 and S3 on (6'b000101), regardless of polarity.
- R6: In the non-feeding interval, with the current-over flag at 0 and the voltage-over flag at 1, the buffer-discharge pattern is driven: exactly S5 and S6 on (6'b110000).
- R7: In the non-feeding interval, with the current-over flag at 1, all six gates are off (6'b000000) whatever the voltage-over flag is.
- R8: The duty word and all three flags are captured on the clock edge that starts a period. A change on any of them later in the period has no effect on the gates until the next period starts.
- R9: A captured duty of PERIOD or more makes the whole period a feeding interval. A duty of 0 gives a period with no feeding cycle.
- R10: While reset is asserted or enable is low, all six gates are off and the carrier is held at zero. The first period starts on the first clock edge that samples enable high.
- R11: S1 and S2 are never on together, S3 and S4 are never on together, and no bridge switch is on while a buffer switch is on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Run enable; low forces the gates off and the carrier to zero |
| duty_i | input | DUTY_W | Feeding-interval length in clock cycles |
| pol_pos_i | input | 1 | Output polarity, 1 = positive |
| il_over_i | input | 1 | Inductor current above its limit |
| vb_over_i | input | 1 | Buffer voltage above its limit |
| gate_o | output | 6 | Gate commands, bit 0 = S1 up to bit 5 = S6 |

## Verification
The assertions assume that enable stays low while the internal reset synchronizer is releasing. The stimulus therefore holds enable low for several cycles after every reset before it starts a run. The flag and duty inputs are assumed to be synchronous to the clock. The bench changes them only just after a falling edge, either at period boundaries or on every cycle in the phase that exercises R8. Duty values span 0, values inside the period, the period itself, and values well past it. Enable is dropped and reset is pulsed in the middle of a period to check the restart behaviour.

// File: rtl/cspwm_pkg.sv
package cspwm_pkg;

  // Sampled condition flags, held for one switching period
  typedef struct packed {
    logic pos;      // output polarity positive
    logic il_over;  // inductor current above limit
    logic vb_over;  // buffer voltage above limit
  } cond_t;

  typedef enum logic [2:0] {
    DRV_IDLE     = 3'd0,
    DRV_FEED_POS = 3'd1,
    DRV_FEED_NEG = 3'd2,
    DRV_MAGNET   = 3'd3,
    DRV_DISCHG   = 3'd4,
    DRV_CHARGE   = 3'd5
  } drive_e;

  // Gate bus bit positions: 0=S1 .. 5=S6
  localparam logic [5:0] PAT_OFF      = 6'b000000;
  localparam logic [5:0] PAT_FEED_POS = 6'b001001;
  localparam logic [5:0] PAT_FEED_NEG = 6'b000110;
  localparam logic [5:0] PAT_MAGNET   = 6'b000101;
  localparam logic [5:0] PAT_DISCHG   = 6'b110000;

endpackage

// File: rtl/cspwm_carrier.sv
module cspwm_carrier #(
  parameter int PERIOD = 2000,
  parameter int CNT_W  = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  output logic             run_o,
  output logic             load_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    run_d = en_i;
    if (!en_i || !run_q) begin
      cnt_d = '0;
    end else if (at_last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  // A new period opens on the edge that starts a run or ends the last cycle
  assign load_o = en_i && (!run_q || at_last);
  assign run_o  = run_q;
  assign cnt_o  = cnt_q;

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && en_i && at_last) |=> (cnt_q == '0)); // R1

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && en_i && !at_last) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1

endmodule

// File: rtl/cspwm_sampler.sv
module cspwm_sampler
  import cspwm_pkg::*;
#(
  parameter int PERIOD = 2000,
  parameter int DUTY_W = 12,
  parameter int CNT_W  = $clog2(PERIOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  cond_t             cond_i,
  output logic [CNT_W:0]    duty_o,
  output cond_t             cond_o
);

  localparam int CMP_W = (DUTY_W > CNT_W + 1) ? DUTY_W : CNT_W + 1;
  localparam logic [CMP_W-1:0] PER_EXT = CMP_W'(PERIOD);

  logic [CMP_W-1:0] duty_ext;
  logic [CNT_W:0]   duty_clamped;
  logic [CNT_W:0]   duty_q, duty_d;
  cond_t            cond_q, cond_d;

  assign duty_ext = CMP_W'(duty_i);

  always_comb begin
    if (duty_ext >= PER_EXT) begin
      duty_clamped = (CNT_W + 1)'(PERIOD);
    end else begin
      duty_clamped = (CNT_W + 1)'(duty_ext);
    end
  end

  // Clock enable: capture only at the period boundary
  always_comb begin
    duty_d = duty_q;
    cond_d = cond_q;
    if (load_i) begin
      duty_d = duty_clamped;
      cond_d = cond_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      cond_q <= '0;
    end else begin
      duty_q <= duty_d;
      cond_q <= cond_d;
    end
  end

  assign duty_o = duty_q;
  assign cond_o = cond_q;

endmodule

// File: rtl/cspwm_gate_decode.sv
module cspwm_gate_decode
  import cspwm_pkg::*;
#(
  parameter int PERIOD = 2000,
  parameter int CNT_W  = $clog2(PERIOD)
) (
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W:0]   duty_i,
  input  cond_t            cond_i,
  output logic             feed_o,
  output logic [5:0]       gate_o
);

  drive_e drv;
  logic   feed;

  assign feed = ({1'b0, cnt_i} < duty_i);

  // Current limit outranks the buffer-voltage limit
  always_comb begin
    if (!run_i) begin
      drv = DRV_IDLE;
    end else if (feed) begin
      drv = cond_i.pos ? DRV_FEED_POS : DRV_FEED_NEG;
    end else if (cond_i.il_over) begin
      drv = DRV_CHARGE;
    end else if (cond_i.vb_over) begin
      drv = DRV_DISCHG;
    end else begin
      drv = DRV_MAGNET;
    end
  end

  always_comb begin
    case (drv)
      DRV_FEED_POS: gate_o = PAT_FEED_POS;
      DRV_FEED_NEG: gate_o = PAT_FEED_NEG;
      DRV_MAGNET:   gate_o = PAT_MAGNET;
      DRV_DISCHG:   gate_o = PAT_DISCHG;
      default:      gate_o = PAT_OFF;
    endcase
  end

  assign feed_o = feed && run_i;

endmodule

// File: rtl/cspwm_sequencer.sv
module cspwm_sequencer
  import cspwm_pkg::*;
#(
  parameter int PERIOD = 2000,
  parameter int DUTY_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              pol_pos_i,
  input  logic              il_over_i,
  input  logic              vb_over_i,
  output logic [5:0]        gate_o
);

  localparam int CNT_W = $clog2(PERIOD);
  localparam logic [CNT_W:0] DUTY_FULL = (CNT_W + 1)'(PERIOD);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic             run, load, feed;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   duty_h;
  cond_t            cond_in, cond_h;

  assign cond_in = '{pos: pol_pos_i, il_over: il_over_i, vb_over: vb_over_i};

  cspwm_carrier #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_carrier (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .en_i   (en_i),
    .run_o  (run),
    .load_o (load),
    .cnt_o  (cnt)
  );

  cspwm_sampler #(.PERIOD(PERIOD), .DUTY_W(DUTY_W), .CNT_W(CNT_W)) u_sampler (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .load_i (load),
    .duty_i (duty_i),
    .cond_i (cond_in),
    .duty_o (duty_h),
    .cond_o (cond_h)
  );

  cspwm_gate_decode #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_decode (
    .run_i  (run),
    .cnt_i  (cnt),
    .duty_i (duty_h),
    .cond_i (cond_h),
    .feed_o (feed),
    .gate_o (gate_o)
  );

  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !(gate_o[0] && gate_o[1]) && !(gate_o[2] && gate_o[3])); // R11

  AST_LEG_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (|gate_o[3:0]) |-> !(|gate_o[5:4])); // R11

  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !$past(en_i) |-> (gate_o == PAT_OFF)); // R10

  AST_FULL_FEED: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (run && duty_h == DUTY_FULL) |-> (gate_o == PAT_FEED_POS || gate_o == PAT_FEED_NEG)); // R9

  AST_ZERO_FEED: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (run && duty_h == '0) |-> !(gate_o == PAT_FEED_POS || gate_o == PAT_FEED_NEG)); // R9

  AST_COND_HELD: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (run && cnt != '0) |-> ($stable(cond_h) && $stable(duty_h))); // R8

  AST_FEED_PREFIX: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (run && !feed && cnt != '0) |=> (!feed || cnt == '0)); // R2

endmodule

// File: tb/cspwm_sequencer_test.sv
module cspwm_sequencer_test;

  localparam int P  = 20;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [DW-1:0] duty = '0;
  logic          pol = 1'b1;
  logic          ilo = 1'b0;
  logic          vbo = 1'b0;
  logic [5:0]    gate;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  cspwm_sequencer #(.PERIOD(P), .DUTY_W(DW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en),
    .duty_i    (duty),
    .pol_pos_i (pol),
    .il_over_i (ilo),
    .vb_over_i (vbo),
    .gate_o    (gate)
  );

  // Behavioural reference: period position and captured values
  int m_pos_in_period;
  bit m_active;
  int m_feed_len;
  bit m_p, m_i, m_v;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active <= 0; m_pos_in_period <= 0; m_feed_len <= 0;
      m_p <= 0; m_i <= 0; m_v <= 0;
    end else begin
      if (en && (!m_active || m_pos_in_period == P - 1)) begin
        m_feed_len <= (int'(duty) > P) ? P : int'(duty);
        m_p <= pol; m_i <= ilo; m_v <= vbo;
      end
      if (!en || !m_active) m_pos_in_period <= 0;
      else m_pos_in_period <= (m_pos_in_period + 1) % P;
      m_active <= en;
    end
  end

  always @(negedge clk) begin
    logic [5:0] exp_g;
    string tag;
    if (!done) begin
      if (!m_active) begin exp_g = 6'b000000; tag = "R10"; end
      else if (m_pos_in_period < m_feed_len) begin
        if (m_p) begin exp_g = 6'b001001; tag = "R3"; end
        else     begin exp_g = 6'b000110; tag = "R4"; end
      end else if (m_i) begin exp_g = 6'b000000; tag = "R7"; end
      else if (m_v)     begin exp_g = 6'b110000; tag = "R6"; end
      else              begin exp_g = 6'b000101; tag = "R5"; end
      vectors++;
      if (gate !== exp_g) begin
        fails++;
        $display("FAIL %s (also R1/R2/R8/R9 timing) t=%0t gate=%b expected=%b", tag, $time, gate, exp_g);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_cond(bit p, bit i, bit v);
    pol = p; ilo = i; vbo = v;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : stim
    step(3);
    // R10: reset state
    vectors++;
    if (gate !== 6'b0) begin
      fails++; $display("FAIL R10 reset gate=%b expected=000000", gate);
    end
    rst_n = 1'b1;
    step(5);
    // R5, R3: magnetize plus positive feed
    duty = 8; set_cond(1, 0, 0); en = 1'b1;
    step(3 * P);
    // R4: negative feed, magnetize pattern unchanged by polarity
    set_cond(0, 0, 0); step(2 * P);
    // R6: buffer discharge
    set_cond(1, 0, 1); step(2 * P);
    // R7: charge, with and without voltage flag
    set_cond(0, 1, 0); step(2 * P);
    set_cond(1, 1, 1); step(2 * P);
    // R9: duty boundaries
    duty = 0;    step(2 * P);
    duty = P;    step(2 * P);
    duty = 200;  set_cond(0, 0, 1); step(2 * P);
    duty = P - 1; step(2 * P);
    duty = 1;    step(2 * P);
    // R8: inputs toggle every cycle; only boundary values count
    for (int k = 0; k < 12 * P; k++) begin
      duty = DW'($urandom_range(0, 30));
      set_cond(1'($urandom), 1'($urandom), 1'($urandom));
      step(1);
    end
    // R10: enable drop mid-period and restart
    duty = 7; set_cond(1, 0, 0); step(5);
    en = 1'b0; step(7);
    en = 1'b1; step(3 * P + 4);
    // R10: async reset mid-run
    rst_n = 1'b0; step(3);
    en = 1'b0; rst_n = 1'b1; step(5);
    en = 1'b1; duty = 12; set_cond(0, 0, 0); step(3 * P);
    // R1 long run with mixed conditions
    for (int k = 0; k < 20; k++) begin
      duty = DW'($urandom_range(0, 25));
      set_cond(1'($urandom), 1'($urandom), 1'($urandom));
      step(P);
    end
    en = 1'b0; step(4);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule